// File: doc/BRIEF.md
# ATA Channel Task-File Register Bank

This block is the device-side command-block register file of a two-drive parallel ATA channel. The host reaches it through an 8-bit port: a 3-bit register index, a write strobe and a read strobe. The block keeps a copy of every task-file register for each drive, plus a shadow that holds each register's previous value. It also tracks which drive is selected.

An accepted write to the command index produces a one-cycle command strobe carrying the byte and the target drive. It also marks that drive busy. From that point the drive's status follows an external command engine until the engine reports completion. Completion raises the channel interrupt, and a status read lowers it.

Register reads are gated by which drives are present. A separate control-register input requests a soft reset of both drives on the rising edge of its reset bit.

Top module: `ata_taskfile_bank`

## Requirements
- R1: After hardware reset, both drives' status is 0x50 and their error registers are 0x00. All task-file registers and shadows are 0x00. Drive 0 is selected with select value 0xA0 (drive 1 holds 0xB0). The interrupt and the command strobe are low.
- R2: The register index is `host_addr`. Index 0 is data, 1 is features on write and error on read, 2 to 5 are count, sector, cylinder low and cylinder high, 6 is device/head, and 7 is command on write and status on read. A read of index 0 returns 0xFF.
- R3: An accepted write to indices 1 to 5 updates both drives' copies in the same cycle. Before the update, each copy's old value moves into that register's shadow. Reads always return the current value, never the shadow.
- R4: A write to index 6 stores (value & ~0x10) | 0xA0 for drive 0 and value | 0xB0 for drive 1. Bit 4 of the value selects the active drive, and reads of index 6 return the selected drive's copy.
- R5: While the selected drive's status has bit 7 (busy) or bit 3 (data request) set, writes to indices 0 to 6 are discarded. Writes to index 7 are always taken.
- R6: An accepted command write raises `cmd_valid` for one cycle on the next clock edge, with `cmd_byte` and `cmd_drive`. On that same edge the target drive's status becomes 0x80.
- R7: A command write while drive 1 is selected and `drv1_present` is low is ignored. No strobe is raised and that drive's status is unchanged.
- R8: With neither drive present, reads of indices 2 to 6 return 0. Reads of indices 1 and 7 also return 0 when drive 1 is selected and absent.
- R9: While a command is active, each clock loads the drive's status as {busy, 1, 0, 1, drq, 0, 0, err} from the engine inputs. On `eng_done`, the status becomes 0x50 | err, the error register becomes 0x04 if err is set and 0x00 otherwise, and `irq` rises.
- R10: A read of index 7 lowers `irq` on the following edge, unless a completion arrives in the same cycle.
- R11: A control write whose reset bit is 1 after a last written value of 0 pulses `soft_reset` for one cycle. It abandons any active command, sets both statuses to 0x50 and both error registers to 0x01, and lowers `irq`. A write that repeats a 1 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register index |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_srst | input | 1 | Reset bit (bit 2) of the control register write |
| drv0_present | input | 1 | Drive 0 is attached |
| drv1_present | input | 1 | Drive 1 is attached |
| eng_busy | input | 1 | Command engine busy bit |
| eng_drq | input | 1 | Command engine data-request bit |
| eng_err | input | 1 | Command engine error bit |
| eng_done | input | 1 | Command engine completion pulse |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Command byte |
| cmd_drive | output | 1 | Drive targeted by the command |
| sel_drive | output | 1 | Currently selected drive |
| irq | output | 1 | Channel interrupt request |
| soft_reset | output | 1 | One-cycle soft reset pulse |

## Verification
Read data is combinational: it is due in the cycle `host_addr` is set, and the bench samples it one time unit after driving the index at a falling edge. Register updates, the command strobe, the busy status, the soft reset pulse and the interrupt are due after one rising edge, so the bench checks them at the falling edge that follows that edge. Status that follows the engine lags the engine inputs by one edge. For that reason the 0x80 value of R6 is sampled in the one cycle before the engine values take over.

// File: rtl/ata_taskfile_bank.sv
module ata_taskfile_bank #(
  parameter int DW = 8,
  parameter logic [DW-1:0] IDLE_STS = 8'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [2:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          ctl_wr,
  input  logic          ctl_srst,
  input  logic          drv0_present,
  input  logic          drv1_present,
  input  logic          eng_busy,
  input  logic          eng_drq,
  input  logic          eng_err,
  input  logic          eng_done,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_byte,
  output logic          cmd_drive,
  output logic          sel_drive,
  output logic          irq,
  output logic          soft_reset
);
  localparam int NREG = 8;
  localparam logic [DW-1:0] BSY_STS = 8'h80;
  localparam logic [DW-1:0] SEL0_BASE = 8'hA0;
  localparam logic [DW-1:0] SEL1_BASE = 8'hB0;

  logic [DW-1:0] tf_cur [0:1][0:NREG-1];
  logic [DW-1:0] tf_hob [0:1][0:NREG-1];
  logic [DW-1:0] sel_reg [0:1];
  logic [DW-1:0] sts_q [0:1];
  logic [DW-1:0] err_q [0:1];
  logic sel_q, act_q, act_drv, irq_q, srst_last, cmd_valid_q, cmd_drive_q, srst_q;
  logic [DW-1:0] cmd_byte_q;

  wire none_present = !drv0_present && !drv1_present;
  wire sel_gone     = sel_q && !drv1_present;
  wire locked       = sts_q[sel_q][7] | sts_q[sel_q][3];
  wire wr_ok        = host_wr && (host_addr == 3'd7 || !locked);
  wire tf_wr        = wr_ok && host_addr >= 3'd1 && host_addr <= 3'd5;
  wire cmd_ok       = host_wr && host_addr == 3'd7 && !sel_gone;
  wire srst         = ctl_wr && ctl_srst && !srst_last;
  wire done_fire    = act_q && eng_done && !srst && !cmd_ok;
  wire [DW-1:0] eng_sts = {eng_busy, 1'b1, 1'b0, 1'b1, eng_drq, 2'b00, eng_err};

  always_comb begin
    case (host_addr)
      3'd0:    host_rdata = 8'hFF;
      3'd1:    host_rdata = (none_present || sel_gone) ? '0 : err_q[sel_q];
      3'd6:    host_rdata = none_present ? '0 : sel_reg[sel_q];
      3'd7:    host_rdata = (none_present || sel_gone) ? '0 : sts_q[sel_q];
      default: host_rdata = none_present ? '0 : tf_cur[sel_q][host_addr];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        for (int r = 0; r < NREG; r++) begin
          tf_cur[d][r] <= '0;
          tf_hob[d][r] <= '0;
        end
        sts_q[d] <= IDLE_STS;
        err_q[d] <= '0;
      end
      sel_reg[0]  <= SEL0_BASE;
      sel_reg[1]  <= SEL1_BASE;
      sel_q       <= 1'b0;
      act_q       <= 1'b0;
      act_drv     <= 1'b0;
      irq_q       <= 1'b0;
      srst_last   <= 1'b0;
      srst_q      <= 1'b0;
      cmd_valid_q <= 1'b0;
      cmd_drive_q <= 1'b0;
      cmd_byte_q  <= '0;
    end else begin
      cmd_valid_q <= cmd_ok;
      srst_q      <= srst;
      if (cmd_ok) begin
        cmd_byte_q  <= host_wdata;
        cmd_drive_q <= sel_q;
      end
      if (ctl_wr) srst_last <= ctl_srst;
      if (tf_wr) begin
        for (int d = 0; d < 2; d++) begin
          tf_hob[d][host_addr] <= tf_cur[d][host_addr];
          tf_cur[d][host_addr] <= host_wdata;
        end
      end
      if (wr_ok && host_addr == 3'd6) begin
        sel_reg[0] <= (host_wdata & ~8'h10) | SEL0_BASE;
        sel_reg[1] <= host_wdata | SEL1_BASE;
        sel_q      <= host_wdata[4];
      end
      if (host_rd && host_addr == 3'd7) irq_q <= 1'b0;
      if (srst) begin
        act_q <= 1'b0;
        irq_q <= 1'b0;
        for (int d = 0; d < 2; d++) begin
          sts_q[d] <= IDLE_STS;
          err_q[d] <= 8'h01;
        end
      end else if (cmd_ok) begin
        act_q        <= 1'b1;
        act_drv      <= sel_q;
        sts_q[sel_q] <= BSY_STS;
      end else if (done_fire) begin
        act_q          <= 1'b0;
        sts_q[act_drv] <= IDLE_STS | {7'd0, eng_err};
        err_q[act_drv] <= eng_err ? 8'h04 : 8'h00;
        irq_q          <= 1'b1;
      end else if (act_q) begin
        sts_q[act_drv] <= eng_sts;
      end
    end
  end

  assign cmd_valid  = cmd_valid_q;
  assign cmd_byte   = cmd_byte_q;
  assign cmd_drive  = cmd_drive_q;
  assign sel_drive  = sel_q;
  assign irq        = irq_q;
  assign soft_reset = srst_q;

  AST_CMD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(host_wr && host_addr == 3'd7)); // R6
  AST_BSY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !soft_reset) |-> sts_q[cmd_drive] == BSY_STS); // R6
  AST_NO_ABSENT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_drive) |-> $past(drv1_present)); // R7
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd2 && locked) |=> $stable(tf_cur[0][2])); // R5
  AST_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd3 && !locked) |=> tf_hob[1][3] == $past(tf_cur[1][3])); // R3
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd7 && !(act_q && eng_done)) |=> !irq); // R10
  AST_SEL_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    sel_reg[0][7] && sel_reg[0][5] && !sel_reg[0][4] && sel_reg[1][4]); // R4
endmodule

// File: tb/tb_ata_taskfile_bank.sv
module tb_ata_taskfile_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;
  // {is_read, index, data or expected}
  localparam logic [11:0] VEC [NVEC] = '{
    12'h211, 12'hA11, // R3 write then read count
    12'h222, 12'hA22, // R3 second write reads current, not shadow
    12'h333, 12'hB33, 12'h444, 12'hC44, 12'h555, 12'hD55, // R3
    12'h166, 12'h900, // R2 features write, error read
    12'h8FF,          // R2 data byte read
    12'h610, 12'hEB0, // R4 select drive 1
    12'hA22,          // R3 drive 1 copy got the broadcast
    12'h64F, 12'hEEF, // R4 drive 0 encoding
    12'hF50           // R2 status read
  };

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0, ctl_wr = 0, ctl_srst = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic drv0_present = 1, drv1_present = 1;
  logic eng_busy = 0, eng_drq = 0, eng_err = 0, eng_done = 0;
  logic [7:0] host_rdata, cmd_byte;
  logic cmd_valid, cmd_drive, sel_drive, irq, soft_reset;
  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  ata_taskfile_bank dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ctl_wr(ctl_wr), .ctl_srst(ctl_srst), .drv0_present(drv0_present),
    .drv1_present(drv1_present), .eng_busy(eng_busy), .eng_drq(eng_drq),
    .eng_err(eng_err), .eng_done(eng_done), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .cmd_drive(cmd_drive), .sel_drive(sel_drive),
    .irq(irq), .soft_reset(soft_reset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); host_rd = 1; host_addr = a;
    #1 chk(host_rdata, exp, tag);
    @(negedge clk); host_rd = 0;
  endtask

  task automatic ctl(input logic b);
    @(negedge clk); ctl_wr = 1; ctl_srst = b;
    @(negedge clk); ctl_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk({7'd0, irq}, 8'h00, "R1 irq");
    chk({7'd0, cmd_valid}, 8'h00, "R1 cmd_valid");
    chk({7'd0, sel_drive}, 8'h00, "R1 sel_drive");
    rd(3'd2, 8'h00, "R1 count"); rd(3'd5, 8'h00, "R1 cyl high");
    rd(3'd1, 8'h00, "R1 error"); rd(3'd6, 8'hA0, "R1 select");
    rd(3'd7, 8'h50, "R1 status");

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][11]) rd(VEC[i][10:8], VEC[i][7:0], $sformatf("R2/R3/R4 table row %0d", i));
      else wr(VEC[i][10:8], VEC[i][7:0]);
    end

    // R6 command strobe and busy status
    wr(3'd6, 8'h00);
    eng_busy = 1;
    wr(3'd7, 8'hEC);
    host_addr = 3'd7;
    #1 chk({7'd0, cmd_valid}, 8'h01, "R6 strobe");
    chk(cmd_byte, 8'hEC, "R6 byte");
    chk({7'd0, cmd_drive}, 8'h00, "R6 drive");
    chk(host_rdata, 8'h80, "R6 busy status");
    @(negedge clk);
    chk({7'd0, cmd_valid}, 8'h00, "R6 one cycle");
    // R9 engine follow, R5 lockout
    rd(3'd7, 8'hD0, "R9 follow busy");
    wr(3'd2, 8'h99);
    rd(3'd2, 8'h22, "R5 locked by busy");
    @(negedge clk); eng_busy = 0; eng_drq = 1;
    rd(3'd7, 8'h58, "R9 follow drq");
    wr(3'd3, 8'h77);
    rd(3'd3, 8'h33, "R5 locked by drq");
    @(negedge clk); eng_drq = 0; eng_err = 1; eng_done = 1;
    @(negedge clk); eng_done = 0; eng_err = 0;
    chk({7'd0, irq}, 8'h01, "R9 irq raised");
    rd(3'd1, 8'h04, "R9 error code");
    rd(3'd7, 8'h51, "R9 final status");
    chk({7'd0, irq}, 8'h00, "R10 irq lowered by status read");
    wr(3'd3, 8'h3A);
    rd(3'd3, 8'h3A, "R5 unlocked after completion");

    // R7 / R8 absent drive 1
    drv1_present = 0;
    wr(3'd6, 8'h10);
    wr(3'd7, 8'h20);
    chk({7'd0, cmd_valid}, 8'h00, "R7 no strobe");
    rd(3'd7, 8'h00, "R8 status gated");
    rd(3'd1, 8'h00, "R8 error gated");
    wr(3'd2, 8'h3C);
    rd(3'd2, 8'h3C, "R7 drive 1 not busy; R8 count readable");
    drv0_present = 0;
    rd(3'd2, 8'h00, "R8 none present count");
    rd(3'd6, 8'h00, "R8 none present select");
    drv0_present = 1; drv1_present = 1;

    // R11 soft reset
    wr(3'd6, 8'h00);
    eng_busy = 1;
    wr(3'd7, 8'h30);
    ctl(1'b1);
    chk({7'd0, soft_reset}, 8'h01, "R11 pulse");
    eng_busy = 0;
    rd(3'd7, 8'h50, "R11 status idle");
    rd(3'd1, 8'h01, "R11 error code");
    ctl(1'b1);
    chk({7'd0, soft_reset}, 8'h00, "R11 repeated bit ignored");
    ctl(1'b0);
    ctl(1'b1);
    chk({7'd0, soft_reset}, 8'h01, "R11 new rising edge");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule